// File: doc/BRIEF.md
# Multichannel Automute Detector

The detector watches eight signed 24-bit audio channels that arrive together as one parallel sample set, qualified by a valid strobe. When every channel has stayed quiet for a programmed number of consecutive sample sets, it raises a mute flag. A quiet channel is one whose magnitude is smaller than a power of two chosen by a bit position. The mute is dropped on the first sample set in which any channel reaches a release threshold. That threshold is either the quiet threshold itself or a level a fixed number of bit positions higher. The higher choice gives asymmetric hysteresis, so low-level noise above the quiet level does not break the mute.

The detector is a three-state machine. `AM_IDLE` is held while the function is disabled. `AM_COUNT` counts consecutive quiet sample sets. `AM_MUTED` holds the mute until a loud sample arrives. The transitions are:

- enable (`AM_IDLE` to `AM_COUNT`)
- quiet run complete (`AM_COUNT` to `AM_MUTED`)
- loud release (`AM_MUTED` to `AM_COUNT`)
- disable (any state to `AM_IDLE`)

A non-quiet sample in `AM_COUNT` is the restart transition, which stays in `AM_COUNT` with the count cleared. A per-channel quiet vector is also reported for the most recent sample set. Gain ramping and the actual silencing of audio belong to the block that consumes the flag.

Top module: `automute_detector`

## Requirements
- R1: After reset, `mute_all` and every bit of `ch_quiet` are 0.
- R2: A channel is quiet when its magnitude is below 2^`cfg_thr_bit` (`cfg_thr_bit` 0 to 15). Bit i of `ch_quiet` gives that result for channel i (data bits [24i+23:24i]) of the last valid sample set taken while enabled. It updates at the clock edge that takes the set.
- R3: Magnitude is the absolute value of the two's-complement sample, and the code -2^23 saturates to 2^23-1.
- R4: `mute_all` rises at the clock edge that takes the max(`cfg_duration`,1)-th consecutive valid sample set in which all eight channels are quiet. Cycles without `smp_valid` do not break the run.
- R5: While not muted, a valid sample set with any non-quiet channel restarts the run from zero.
- R6: While muted, a single valid sample set in which any channel's magnitude is at least the release threshold clears `mute_all` at that edge. A new run then starts from zero.
- R7: With `cfg_wide_release`=0 the release threshold is 2^`cfg_thr_bit`. With 1 it is 2^(`cfg_thr_bit`+2). Magnitudes between the quiet and release thresholds keep the mute.
- R8: While `cfg_enable`=0, `mute_all` and `ch_quiet` are 0 from the next edge on and samples are ignored. After re-enabling, one idle cycle passes and a fresh run of R4 is needed.
- R9: While muted, valid sample sets below the release threshold keep `mute_all` at 1 however long they last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample set on `smp_data` is valid this cycle |
| smp_data | input | 192 | Eight signed 24-bit samples, channel i in bits [24i+23:24i] |
| cfg_enable | input | 1 | Automute enable |
| cfg_thr_bit | input | 4 | Quiet threshold as bit position |
| cfg_duration | input | 16 | Number of consecutive quiet sample sets before muting |
| cfg_wide_release | input | 1 | Release threshold choice: 0 equal to quiet threshold, 1 two bits higher |
| mute_all | output | 1 | Automute active |
| ch_quiet | output | 8 | Per-channel quiet flags of the last sample set |

## Verification
Both results are due one register stage after the stimulus. `ch_quiet` and `mute_all` change at the same rising edge that takes the valid sample set, and disabling takes effect at the first edge after `cfg_enable` falls. The bench drives each sample set at a falling edge, holds it for exactly one rising edge, and samples both outputs at the following falling edge, so each expected value is compared one edge after its cause. After enabling, the bench waits two edges before the first sample so that the idle-to-count transition has completed.

// File: rtl/automute_pkg.sv
package automute_pkg;

    typedef enum logic [1:0] {
        AM_IDLE  = 2'd0,
        AM_COUNT = 2'd1,
        AM_MUTED = 2'd2
    } am_state_t;

endpackage

// File: rtl/amute_level_cmp.sv
module amute_level_cmp #(
    parameter int SAMPLE_W   = 24,
    parameter int THR_W      = 4,
    parameter int HYST_SHIFT = 2
) (
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic [THR_W-1:0]    thr_bit_i,
    input  logic                wide_i,
    output logic                quiet_o,
    output logic                loud_o
);

    localparam int MAG_W = SAMPLE_W - 1;

    logic [SAMPLE_W-1:0] neg_v;
    logic [MAG_W-1:0]    mag;
    logic [THR_W:0]      rel_bit;

    // R3: absolute value, most negative code saturated
    always_comb begin
        neg_v = -sample_i;
        if (sample_i == {1'b1, {MAG_W{1'b0}}})
            mag = {MAG_W{1'b1}};
        else if (sample_i[SAMPLE_W-1])
            mag = neg_v[MAG_W-1:0];
        else
            mag = sample_i[MAG_W-1:0];
    end

    // R2 / R7: power-of-two compares as shifted zero tests
    always_comb begin
        rel_bit = {1'b0, thr_bit_i} + (wide_i ? (THR_W+1)'(HYST_SHIFT) : '0);
        quiet_o = ((mag >> thr_bit_i) == '0);
        loud_o  = ((mag >> rel_bit) != '0);
    end

    // a release-level sample can never also be quiet (R7)
    always_comb begin
        p_quiet_excl_loud_r7: assert (!(quiet_o && loud_o))
            else $error("quiet and loud both set");
    end

endmodule

// File: rtl/amute_fsm.sv
module amute_fsm
    import automute_pkg::*;
#(
    parameter int DUR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic             valid_i,
    input  logic             all_quiet_i,
    input  logic             any_loud_i,
    input  logic [DUR_W-1:0] duration_i,
    output logic             mute_o
);

    am_state_t        state_q, state_d;
    logic [DUR_W-1:0] cnt_q, cnt_d;
    logic [DUR_W:0]   cnt_inc;

    always_comb cnt_inc = {1'b0, cnt_q} + 1'b1;

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!enable_i) begin
            state_d = AM_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                AM_IDLE: begin
                    state_d = AM_COUNT;
                    cnt_d   = '0;
                end
                AM_COUNT: begin
                    if (valid_i) begin
                        if (!all_quiet_i) begin
                            cnt_d = '0;
                        end else if (cnt_inc >= {1'b0, duration_i}) begin
                            state_d = AM_MUTED;
                        end else begin
                            cnt_d = cnt_inc[DUR_W-1:0];
                        end
                    end
                end
                AM_MUTED: begin
                    if (valid_i && any_loud_i) begin
                        state_d = AM_COUNT;
                        cnt_d   = '0;
                    end
                end
                default: begin
                    state_d = AM_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= AM_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb mute_o = (state_q == AM_MUTED);

    p_mute_needs_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(mute_o) && mute_o) |-> $past(valid_i && all_quiet_i && enable_i))
        else $error("mute rose without a quiet sample");

    p_restart_on_noise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && state_q == AM_COUNT && valid_i && !all_quiet_i) |=> (cnt_q == '0 && !mute_o))
        else $error("noisy sample did not restart the run");

    p_release_needs_loud_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mute_o) && !mute_o && $past(enable_i)) |-> $past(valid_i && any_loud_i))
        else $error("mute released without a loud sample");

    p_hold_while_soft_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mute_o && enable_i && !(valid_i && any_loud_i)) |=> mute_o)
        else $error("mute dropped without cause");

    p_disabled_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> !mute_o)
        else $error("mute while disabled");

endmodule

// File: rtl/automute_detector.sv
module automute_detector #(
    parameter int NUM_CH     = 8,
    parameter int SAMPLE_W   = 24,
    parameter int THR_W      = 4,
    parameter int DUR_W      = 16,
    parameter int HYST_SHIFT = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         smp_valid,
    input  logic [NUM_CH*SAMPLE_W-1:0]   smp_data,
    input  logic                         cfg_enable,
    input  logic [THR_W-1:0]             cfg_thr_bit,
    input  logic [DUR_W-1:0]             cfg_duration,
    input  logic                         cfg_wide_release,
    output logic                         mute_all,
    output logic [NUM_CH-1:0]            ch_quiet
);

    logic [NUM_CH-1:0] quiet_vec;
    logic [NUM_CH-1:0] loud_vec;
    logic              all_quiet;
    logic              any_loud;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        amute_level_cmp #(
            .SAMPLE_W  (SAMPLE_W),
            .THR_W     (THR_W),
            .HYST_SHIFT(HYST_SHIFT)
        ) u_cmp (
            .sample_i (smp_data[c*SAMPLE_W +: SAMPLE_W]),
            .thr_bit_i(cfg_thr_bit),
            .wide_i   (cfg_wide_release),
            .quiet_o  (quiet_vec[c]),
            .loud_o   (loud_vec[c])
        );
    end

    always_comb begin
        all_quiet = &quiet_vec;
        any_loud  = |loud_vec;
    end

    // per-channel quiet flags of the last taken sample set
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ch_quiet <= '0;
        else if (!cfg_enable)
            ch_quiet <= '0;
        else if (smp_valid)
            ch_quiet <= quiet_vec;
    end

    amute_fsm #(
        .DUR_W(DUR_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable_i   (cfg_enable),
        .valid_i    (smp_valid),
        .all_quiet_i(all_quiet),
        .any_loud_i (any_loud),
        .duration_i (cfg_duration),
        .mute_o     (mute_all)
    );

    p_flags_cleared_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> (ch_quiet == '0))
        else $error("channel flags set while disabled");

    p_mute_implies_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(mute_all) && mute_all) |-> (&ch_quiet))
        else $error("mute rose with a non-quiet channel flag");

endmodule

// File: tb/tb_automute_detector.sv
module tb_automute_detector;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 8;
    localparam int SW  = 24;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                smp_valid = 1'b0;
    logic [NCH*SW-1:0]   smp_data = '0;
    logic                cfg_enable = 1'b0;
    logic [3:0]          cfg_thr_bit = 4'd0;
    logic [15:0]         cfg_duration = 16'd0;
    logic                cfg_wide_release = 1'b0;
    logic                mute_all;
    logic [NCH-1:0]      ch_quiet;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    automute_detector dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .cfg_enable(cfg_enable), .cfg_thr_bit(cfg_thr_bit), .cfg_duration(cfg_duration),
        .cfg_wide_release(cfg_wide_release), .mute_all(mute_all), .ch_quiet(ch_quiet)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit exp_quiet(input int v, input int t);
        longint m;
        m = (v < 0) ? -longint'(v) : longint'(v);
        if (v == -(1 << 23)) m = (1 << 23) - 1;
        return m < (longint'(1) << t);
    endfunction

    // send one sample set with all channels equal to v
    task automatic send_all(input int v);
        for (int c = 0; c < NCH; c++) smp_data[c*SW +: SW] = SW'(v);
        smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic send_one(input int c0, input int v);
        smp_data = '0;
        smp_data[c0*SW +: SW] = SW'(v);
        smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int vals [NCH];
        idle(2);
        check(mute_all == 1'b0, "R1 mute_all", mute_all, 0);
        check(ch_quiet == '0, "R1 ch_quiet", ch_quiet, 0);
        rst_n = 1'b1;
        idle(1);

        // R2 / R3 sweep over every threshold bit
        cfg_enable   = 1'b1;
        cfg_duration = 16'd60000;
        idle(2);
        for (int t = 0; t < 16; t++) begin
            cfg_thr_bit = 4'(t);
            vals[0] = (1 << t) - 1;
            vals[1] = (1 << t);
            vals[2] = -(1 << t);
            vals[3] = -((1 << t) - 1);
            vals[4] = 0;
            vals[5] = -1;
            vals[6] = -(1 << 23);
            vals[7] = (1 << 23) - 1;
            for (int c = 0; c < NCH; c++) smp_data[c*SW +: SW] = SW'(vals[c]);
            smp_valid = 1'b1;
            @(negedge clk);
            smp_valid = 1'b0;
            for (int c = 0; c < NCH; c++)
                check(ch_quiet[c] == exp_quiet(vals[c], t),
                      (c == 6) ? "R3 saturated magnitude" : "R2 quiet flag",
                      ch_quiet[c], exp_quiet(vals[c], t));
        end
        check(mute_all == 1'b0, "R5 no mute with noisy channels", mute_all, 0);

        // R4: run of 3 with gaps in valid
        cfg_thr_bit  = 4'd4;
        cfg_duration = 16'd3;
        send_all(15);
        idle(3);
        send_all(-15);
        check(mute_all == 1'b0, "R4 not yet muted", mute_all, 0);
        idle(2);
        send_all(0);
        check(mute_all == 1'b1, "R4 muted after run", mute_all, 1);

        // R9: quiet samples hold mute
        for (int i = 0; i < 5; i++) send_all(3);
        check(mute_all == 1'b1, "R9 mute held", mute_all, 1);

        // R7: wide release, mid-level noise keeps mute
        cfg_wide_release = 1'b1;
        send_one(2, 63);
        check(mute_all == 1'b1, "R7 mid-level keeps mute", mute_all, 1);
        check(ch_quiet[2] == 1'b0, "R2 mid-level not quiet", ch_quiet[2], 0);
        send_one(5, -64);
        check(mute_all == 1'b0, "R6 wide release", mute_all, 0);

        // R5: restart by noise
        cfg_wide_release = 1'b0;
        send_all(1);
        send_all(1);
        send_one(7, 16);
        send_all(1);
        send_all(1);
        check(mute_all == 1'b0, "R5 run restarted", mute_all, 0);
        send_all(1);
        check(mute_all == 1'b1, "R5 muted after fresh run", mute_all, 1);

        // R6/R7: narrow release at the quiet threshold
        send_one(0, 15);
        check(mute_all == 1'b1, "R7 below threshold keeps mute", mute_all, 1);
        send_one(3, -16);
        check(mute_all == 1'b0, "R6 narrow release", mute_all, 0);

        // R3: most negative code releases at top threshold
        cfg_thr_bit  = 4'd15;
        cfg_duration = 16'd0;
        send_all(100);
        check(mute_all == 1'b1, "R4 duration 0 mutes on first", mute_all, 1);
        send_one(1, -(1 << 23));
        check(mute_all == 1'b0, "R3 most negative releases", mute_all, 0);
        check(ch_quiet[1] == 1'b0, "R3 most negative not quiet", ch_quiet[1], 0);

        // R8: disable
        send_all(0);
        check(mute_all == 1'b1, "R8 muted before disable", mute_all, 1);
        cfg_enable = 1'b0;
        idle(1);
        check(mute_all == 1'b0, "R8 disabled clears mute", mute_all, 0);
        check(ch_quiet == '0, "R8 disabled clears flags", ch_quiet, 0);
        send_all(0);
        send_all(0);
        check(mute_all == 1'b0, "R8 samples ignored", mute_all, 0);
        check(ch_quiet == '0, "R8 flags stay clear", ch_quiet, 0);
        cfg_duration = 16'd2;
        cfg_enable   = 1'b1;
        idle(2);
        send_all(0);
        check(mute_all == 1'b0, "R8 fresh run after enable", mute_all, 0);
        send_all(0);
        check(mute_all == 1'b1, "R8 muted after fresh run", mute_all, 1);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule